// File: doc/BRIEF.md
# DMA Channel Register Interface

This block holds the per-channel register state of a descriptor-ring DMA engine. The engine has a parameterised number of channels. The lower channel indices move data from host to device, and the upper ones move data from device to host. Software reaches every channel through one byte-addressed register window. Each channel has two register halves. The host half holds a control byte, an error byte, a 16-bit available-descriptor pointer that software writes, and a 16-bit processed-descriptor pointer that the engine advances. The device half holds its own control byte and error byte.

A channel counts as active only while both of its control bytes have the start bit set. While a channel is active, each descriptor-done pulse from the engine moves its processed pointer forward by one, until the pointer catches up with the available pointer modulo the ring size. The processed pointer counts from 1 up to the ring size rather than from 0 up to size-1, so software masks it with size-1. A control write that clears the start bit aborts the channel and returns both pointers to zero.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every register reads 0 and every `chan_active` bit is 0.
- R2: Channel c occupies the 32 bytes starting at c*32. For a host-to-device channel (c < DST_START), the host half is at +0x00 and the device half at +0x10. For a device-to-host channel, the two halves swap. The device half has no pointer registers.
- R3: Inside a half, the control byte is at 0x0 (written from wr_data[7:0]), the available pointer is at 0x2 (16 bits), the processed pointer is at 0x4 (16 bits) and the error byte is at 0x8 (wr_data[7:0]). Reads return these values zero-extended to 16 bits.
- R4: `chan_active[c]` is 1 exactly when bit 0 of both the host and the device control bytes of channel c is 1.
- R5: On a `desc_done[c]` pulse, the processed pointer increments by one if the channel is active and the processed pointer differs from the available pointer, both taken modulo RING_DEPTH. Otherwise it holds its value.
- R6: After leaving 0, the processed pointer takes values from 1 to RING_DEPTH. The step after RING_DEPTH is 1.
- R7: A write to the host control byte with bit 0 clear stores the byte and clears both pointers of that channel. This covers plain abort (0x00) and abort-and-pause (0x02).
- R8: Writes to the processed pointer have no effect. Writes to unmapped offsets have no effect. Reads of unmapped offsets return 0.
- R9: `rd_data` is loaded on the clock edge that samples `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 16 | Write data; byte registers take bits 7:0 |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Byte address of the read |
| rd_data | output | 16 | Registered read data |
| desc_done | input | NUM_CH | One descriptor-done pulse per channel |
| chan_active | output | NUM_CH | Per-channel active status |

## Verification
Writes and `desc_done` pulses take effect on the clock edge that samples them. `chan_active` follows combinationally from the stored control bytes, so the bench checks it on the falling edge right after the write. Read data appears one edge after `rd_en`. The bench drives every stimulus on a falling edge and samples on the next falling edge, so each result is read exactly one register stage after its cause. The hold test then checks that `rd_data` stays unchanged across a cycle in which `rd_en` is low.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
   localparam int CH_STRIDE_LOG2 = 5;
   localparam logic CTRL_START   = 1'b1;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_CTRL,
      RK_AVAIL,
      RK_PROC,
      RK_ERR
   } reg_kind_e;

   typedef struct packed {
      logic      hit;
      logic      host;
      reg_kind_e kind;
   } reg_sel_t;

   function automatic reg_kind_e offset_kind(input logic [3:0] off);
      case (off)
         4'h0:    return RK_CTRL;
         4'h2:    return RK_AVAIL;
         4'h4:    return RK_PROC;
         4'h8:    return RK_ERR;
         default: return RK_NONE;
      endcase
   endfunction
endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode
   import dma_regs_pkg::*;
#(
   parameter int NUM_CH    = 8,
   parameter int DST_START = 4,
   parameter int CH_W      = 3,
   parameter int AW        = CH_W + 5
) (
   input  logic [AW-1:0]   addr,
   output logic [CH_W-1:0] ch,
   output reg_sel_t        sel
);
   localparam logic [CH_W:0] NUM_CH_V = (CH_W+1)'(NUM_CH);
   localparam logic [CH_W:0] DST_V    = (CH_W+1)'(DST_START);

   logic      in_range;
   logic      is_dst;
   logic      host_half;
   reg_kind_e kind;

   always_comb begin
      ch        = addr[AW-1:CH_STRIDE_LOG2];
      in_range  = {1'b0, ch} < NUM_CH_V;
      is_dst    = {1'b0, ch} >= DST_V;
      host_half = (addr[CH_STRIDE_LOG2-1] == is_dst);
      kind      = offset_kind(addr[3:0]);
      if (!host_half && (kind == RK_AVAIL || kind == RK_PROC))
         kind = RK_NONE;
      sel.hit  = in_range && (kind != RK_NONE);
      sel.host = host_half;
      sel.kind = kind;
   end
endmodule

// File: rtl/dma_chan_slice.sv
module dma_chan_slice
   import dma_regs_pkg::*;
#(
   parameter int RING_DEPTH = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_host_ctrl,
   input  logic        wr_dev_ctrl,
   input  logic        wr_avail,
   input  logic        wr_host_err,
   input  logic        wr_dev_err,
   input  logic [15:0] wr_data,
   input  logic        done,
   output logic [7:0]  host_ctrl,
   output logic [7:0]  dev_ctrl,
   output logic [15:0] avail,
   output logic [15:0] proc,
   output logic [7:0]  host_err,
   output logic [7:0]  dev_err,
   output logic        active
);
   localparam logic [15:0] MASK    = 16'(RING_DEPTH - 1);
   localparam logic [15:0] DEPTH_V = 16'(RING_DEPTH);

   logic        abort;
   logic        can_step;
   logic [15:0] proc_next;

   assign active    = (host_ctrl[0] == CTRL_START) && (dev_ctrl[0] == CTRL_START);
   assign abort     = wr_host_ctrl && (wr_data[0] != CTRL_START);
   assign can_step  = active && done && ((proc & MASK) != (avail & MASK));
   assign proc_next = (proc == DEPTH_V) ? 16'd1 : proc + 16'd1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_ctrl <= '0;
         dev_ctrl  <= '0;
         host_err  <= '0;
         dev_err   <= '0;
      end else begin
         if (wr_host_ctrl) host_ctrl <= wr_data[7:0];
         if (wr_dev_ctrl)  dev_ctrl  <= wr_data[7:0];
         if (wr_host_err)  host_err  <= wr_data[7:0];
         if (wr_dev_err)   dev_err   <= wr_data[7:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || abort) begin
         avail <= '0;
         proc  <= '0;
      end else begin
         if (wr_avail) avail <= wr_data;
         if (can_step) proc  <= proc_next;
      end
   end
endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux
   import dma_regs_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3
) (
   input  logic [CH_W-1:0]               ch,
   input  reg_sel_t                      sel,
   input  logic [NUM_CH-1:0][7:0]        host_ctrl,
   input  logic [NUM_CH-1:0][7:0]        dev_ctrl,
   input  logic [NUM_CH-1:0][15:0]       avail,
   input  logic [NUM_CH-1:0][15:0]       proc,
   input  logic [NUM_CH-1:0][7:0]        host_err,
   input  logic [NUM_CH-1:0][7:0]        dev_err,
   output logic [15:0]                   data
);
   always_comb begin
      data = '0;
      if (sel.hit) begin
         case (sel.kind)
            RK_CTRL:  data = {8'h00, sel.host ? host_ctrl[ch] : dev_ctrl[ch]};
            RK_ERR:   data = {8'h00, sel.host ? host_err[ch] : dev_err[ch]};
            RK_AVAIL: data = avail[ch];
            RK_PROC:  data = proc[ch];
            default:  data = '0;
         endcase
      end
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_regs_pkg::*;
#(
   parameter int NUM_CH     = 8,
   parameter int DST_START  = 4,
   parameter int RING_DEPTH = 64,
   parameter int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   parameter int AW         = CH_W + 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [15:0]       wr_data,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [15:0]       rd_data,
   input  logic [NUM_CH-1:0] desc_done,
   output logic [NUM_CH-1:0] chan_active
);
   if (NUM_CH < 2 || NUM_CH > 32) begin : g_bad_nch
      $error("NUM_CH must lie in 2..32");
   end
   if (DST_START < 0 || DST_START > NUM_CH) begin : g_bad_dst
      $error("DST_START must lie in 0..NUM_CH");
   end
   if (RING_DEPTH < 2 || RING_DEPTH > 32768 || (RING_DEPTH & (RING_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("RING_DEPTH must be a power of two in 2..32768");
   end

   logic [CH_W-1:0] wr_ch, rd_ch;
   reg_sel_t        wr_sel, rd_sel;
   logic [15:0]     rd_mux;

   logic [NUM_CH-1:0][7:0]  host_ctrl_all, dev_ctrl_all, host_err_all, dev_err_all;
   logic [NUM_CH-1:0][15:0] avail_all, proc_all;

   dma_addr_decode #(.NUM_CH(NUM_CH), .DST_START(DST_START), .CH_W(CH_W), .AW(AW)) u_wr_dec (
      .addr(wr_addr), .ch(wr_ch), .sel(wr_sel)
   );
   dma_addr_decode #(.NUM_CH(NUM_CH), .DST_START(DST_START), .CH_W(CH_W), .AW(AW)) u_rd_dec (
      .addr(rd_addr), .ch(rd_ch), .sel(rd_sel)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit_c;
      assign hit_c = wr_en && wr_sel.hit && (wr_ch == CH_W'(c));

      dma_chan_slice #(.RING_DEPTH(RING_DEPTH)) u_slice (
         .clk          (clk),
         .rst_n        (rst_n),
         .wr_host_ctrl (hit_c && wr_sel.host  && wr_sel.kind == RK_CTRL),
         .wr_dev_ctrl  (hit_c && !wr_sel.host && wr_sel.kind == RK_CTRL),
         .wr_avail     (hit_c && wr_sel.host  && wr_sel.kind == RK_AVAIL),
         .wr_host_err  (hit_c && wr_sel.host  && wr_sel.kind == RK_ERR),
         .wr_dev_err   (hit_c && !wr_sel.host && wr_sel.kind == RK_ERR),
         .wr_data      (wr_data),
         .done         (desc_done[c]),
         .host_ctrl    (host_ctrl_all[c]),
         .dev_ctrl     (dev_ctrl_all[c]),
         .avail        (avail_all[c]),
         .proc         (proc_all[c]),
         .host_err     (host_err_all[c]),
         .dev_err      (dev_err_all[c]),
         .active       (chan_active[c])
      );
   end

   dma_read_mux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rmux (
      .ch(rd_ch), .sel(rd_sel),
      .host_ctrl(host_ctrl_all), .dev_ctrl(dev_ctrl_all),
      .avail(avail_all), .proc(proc_all),
      .host_err(host_err_all), .dev_err(dev_err_all),
      .data(rd_mux)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_mux;
   end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
   parameter int NUM_CH     = 8,
   parameter int RING_DEPTH = 64
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic                    rd_en,
   input logic [15:0]             rd_data,
   input logic [NUM_CH-1:0]       desc_done,
   input logic [NUM_CH-1:0]       chan_active,
   input logic [NUM_CH-1:0][15:0] proc_ptr
);
   localparam logic [15:0] DEPTH_V = 16'(RING_DEPTH);

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_en) |-> $stable(rd_data)); // R9

   for (genvar i = 0; i < NUM_CH; i++) begin : g_a
      AST_ACTIVE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(chan_active[i]) |-> $past(wr_en)); // R4
      AST_PROC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         proc_ptr[i] <= DEPTH_V); // R6
      AST_PROC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(proc_ptr[i]) |-> (proc_ptr[i] == 16'd0)
            || ($past(proc_ptr[i]) != DEPTH_V && proc_ptr[i] == $past(proc_ptr[i]) + 16'd1)
            || ($past(proc_ptr[i]) == DEPTH_V && proc_ptr[i] == 16'd1)); // R5
      AST_PROC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(desc_done[i]) && !$past(wr_en)) |-> $stable(proc_ptr[i])); // R8
   end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH), .RING_DEPTH(RING_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
   .desc_done(desc_done), .chan_active(chan_active), .proc_ptr(proc_all)
);

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
   localparam int NCH = 4, DST = 2, DEPTH = 8, AWB = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0, rd_en = 1'b0;
   logic [AWB-1:0]  wr_addr = '0, rd_addr = '0;
   logic [15:0]     wr_data = '0;
   logic [15:0]     rd_data;
   logic [NCH-1:0]  desc_done = '0;
   logic [NCH-1:0]  chan_active;
   int n_tests = 0, n_fail = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   dma_chan_regs #(.NUM_CH(NCH), .DST_START(DST), .RING_DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .desc_done(desc_done), .chan_active(chan_active)
   );

   function automatic logic [AWB-1:0] hb(input int ch);
      return AWB'(ch * 32 + ((ch >= DST) ? 16 : 0));
   endfunction
   function automatic logic [AWB-1:0] db(input int ch);
      return AWB'(ch * 32 + ((ch >= DST) ? 0 : 16));
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AWB-1:0] a, input logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AWB-1:0] a, output logic [15:0] d);
      @(negedge clk); rd_en = 1'b1; rd_addr = a;
      @(negedge clk); rd_en = 1'b0; d = rd_data;
   endtask

   task automatic pulse(input int ch, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); desc_done[ch] = 1'b1;
         @(negedge clk); desc_done[ch] = 1'b0;
      end
   endtask

   task automatic t_reset;
      logic [15:0] v;
      chk("R1 active", 16'(chan_active), 16'h0);
      rd(hb(0) + 7'h0, v); chk("R1 ctrl", v, 16'h0);
      rd(hb(0) + 7'h2, v); chk("R1 avail", v, 16'h0);
      rd(hb(3) + 7'h4, v); chk("R1 proc", v, 16'h0);
      rd(db(3) + 7'h8, v); chk("R1 err", v, 16'h0);
   endtask

   task automatic t_map;
      logic [15:0] v;
      wr(7'h00, 16'h0001); wr(7'h10, 16'h0001);
      chk("R2 h2d halves", 16'(chan_active[0]), 16'h1);
      wr(7'h48, 16'h00D1); wr(7'h58, 16'h00E2);
      rd(7'h48, v); chk("R2 d2h device err", v, 16'h00D1);
      rd(7'h58, v); chk("R2 d2h host err", v, 16'h00E2);
      wr(7'h52, 16'h0005);
      rd(7'h52, v); chk("R2 d2h host avail", v, 16'h0005);
      rd(7'h42, v); chk("R2 device half no avail", v, 16'h0000);
   endtask

   task automatic t_offsets;
      logic [15:0] v;
      wr(7'h22, 16'h1234); rd(7'h22, v); chk("R3 avail", v, 16'h1234);
      wr(7'h28, 16'h7EA5); rd(7'h28, v); chk("R3 err byte", v, 16'h00A5);
      wr(7'h20, 16'h03C0); rd(7'h20, v); chk("R3 ctrl byte", v, 16'h00C0);
   endtask

   task automatic t_active;
      wr(7'h20, 16'h0001);
      chk("R4 host only", 16'(chan_active[1]), 16'h0);
      wr(7'h30, 16'h0001);
      chk("R4 both", 16'(chan_active[1]), 16'h1);
      wr(7'h20, 16'h0002);
      chk("R4 pause drops", 16'(chan_active[1]), 16'h0);
   endtask

   task automatic t_advance;
      logic [15:0] v;
      wr(7'h02, 16'h0003);
      pulse(0, 1); rd(7'h04, v); chk("R5 one step", v, 16'h0001);
      pulse(0, 4); rd(7'h04, v); chk("R5 stops at avail", v, 16'h0003);
      wr(7'h72, 16'h0004);
      pulse(3, 2); rd(7'h74, v); chk("R5 inactive holds", v, 16'h0000);
   endtask

   task automatic t_wrap_ignore;
      logic [15:0] v;
      wr(7'h00, 16'h0000); wr(7'h00, 16'h0001);
      wr(7'h02, 16'h0007); pulse(0, 7);
      rd(7'h04, v); chk("R6 reach 7", v, 16'h0007);
      wr(7'h02, 16'h0000); pulse(0, 1);
      rd(7'h04, v); chk("R6 reaches depth", v, 16'h0008);
      pulse(0, 1); rd(7'h04, v); chk("R6 full holds", v, 16'h0008);
      wr(7'h02, 16'h0002); pulse(0, 1);
      rd(7'h04, v); chk("R6 wrap to 1", v, 16'h0001);
      pulse(0, 1);
      wr(7'h04, 16'h0006); rd(7'h04, v); chk("R8 proc write ignored", v, 16'h0002);
      wr(7'h06, 16'hBEEF); rd(7'h06, v); chk("R8 unmapped read", v, 16'h0000);
      rd(7'h02, v); chk("R8 unmapped write no effect", v, 16'h0002);
      rd(7'h0C, v); chk("R8 unmapped 0xC", v, 16'h0000);
   endtask

   task automatic t_abort;
      logic [15:0] v;
      wr(7'h00, 16'h0002);
      rd(7'h04, v); chk("R7 proc cleared", v, 16'h0000);
      rd(7'h02, v); chk("R7 avail cleared", v, 16'h0000);
      rd(7'h00, v); chk("R7 ctrl kept", v, 16'h0002);
      chk("R7 inactive", 16'(chan_active[0]), 16'h0);
   endtask

   task automatic t_hold;
      logic [15:0] v;
      wr(7'h28, 16'h0011); rd(7'h28, v); chk("R9 read", v, 16'h0011);
      wr(7'h28, 16'h0022);
      chk("R9 holds without rd_en", rd_data, 16'h0011);
      rd(7'h28, v); chk("R9 new read", v, 16'h0022);
   endtask

   task automatic summary;
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map();
      t_offsets();
      t_active();
      t_advance();
      t_wrap_ignore();
      t_abort();
      t_hold();
      summary();
   end
endmodule